// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands of `WIDTH` bits and returns the full product of `2*WIDTH` bits. All partial-product rows are formed in parallel by AND gates. A row is operand A gated by one bit of operand B and moved left by that bit's index. The rows are then folded together through a chain of 3-to-2 carry-save stages. Each stage keeps its carries as a separate word instead of rippling them along the row.

After `WIDTH-2` such stages only a sum word and a carry word remain. One carry-propagate adder of full product width merges them. An optional output register, chosen with `OUT_REG`, cuts the combinational path and adds one clock of latency. The register has a synchronous active-low reset.

Top module: `csa_array_mult`

## Requirements
- R1: `product` equals the unsigned product of `op_a` and `op_b`, exact over all `2*WIDTH` bits, for every operand pair.
- R2: Partial product bit (i, j) is `op_a[i] & op_b[j]` and carries weight 2^(i+j). With one-hot operands `op_a = 2^i` and `op_b = 2^j`, `product` is exactly 2^(i+j).
- R3: Every carry-save stage takes three words and returns a sum word and a carry word. The carry word is shifted up one bit position. The sum of the two outputs equals the sum of the three inputs.
- R4: No carry is lost in the carry-save chain. The final sum word plus the final carry word equals `op_a * op_b`, including for dense operands such as all-ones.
- R5: The single final carry-propagate adder is `2*WIDTH` bits wide and never produces a carry out. The largest operands, (2^WIDTH-1)^2, give a product with no bit dropped.
- R6: With `OUT_REG=1`, `product` shows the product of the operands sampled at the previous rising clock edge. This gives one cycle of latency.
- R7: With `OUT_REG=1`, a rising edge with `rst_n` low sets `product` to 0. `product` stays 0 for as long as `rst_n` stays low, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Synchronous reset, active low |
| op_a | input | WIDTH | Multiplicand, unsigned |
| op_b | input | WIDTH | Multiplier, unsigned |
| product | output | 2*WIDTH | Unsigned product |

## Verification
On every clock the assertions check four things. Each carry-save stage must conserve the total of its three inputs in its two outputs. The final sum and carry words must add up to the true product. The final adder must never carry out. The registered output must follow the previous cycle's operands, and must be zero after a reset edge.

Some behaviours only the bench scenarios can show. The one-hot sweep shows that each partial-product bit lands at its exact weight. The all-ones operands drive the largest values through the whole datapath. A reset in the middle of a run shows that a reset overrides a pending result. The exhaustive sweep over all operand pairs shows that the product is right everywhere.

// File: rtl/csam_pkg.sv
// Package: shared sizing helpers for the carry-save array multiplier.
// Assumes operand widths of at least two bits.
package csam_pkg;

    // Product width for an n-bit by n-bit unsigned multiply.
    function automatic int prod_width(input int n);
        return 2 * n;
    endfunction

    // Number of 3:2 carry-save stages needed to fold n rows into two words.
    function automatic int csa_stages(input int n);
        return (n > 2) ? n - 2 : 0;
    endfunction

endpackage

// File: rtl/csam_pp_gen.sv
// Module: partial-product generator.
// Forms all N rows at once. Row j is op_a gated by op_b[j], moved left by j.
// Assumes PW >= 2*N so that no row bit falls off the top.
module csam_pp_gen #(
    parameter int N  = 8,
    parameter int PW = 16
) (
    input  logic [N-1:0]          mcand,
    input  logic [N-1:0]          mplier,
    output logic [N-1:0][PW-1:0]  rows
);

    localparam int PAD = PW - N;

    genvar j;
    generate
        for (j = 0; j < N; j++) begin : g_row
            // Gate the multiplicand with one multiplier bit and weight it by 2^j.
            assign rows[j] = {{PAD{1'b0}}, (mcand & {N{mplier[j]}})} << j;
        end
    endgenerate

endmodule

// File: rtl/csam_csa_row.sv
// Module: one 3-to-2 carry-save stage over PW-bit words.
// Each bit position is an independent full adder. The majority outputs form
// the carry word one position higher, and no carry moves sideways.
// Assumes the three inputs sum to less than 2^PW, so the top majority bit is zero.
module csam_csa_row #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] in_x,
    input  logic [PW-1:0] in_y,
    input  logic [PW-1:0] in_z,
    output logic [PW-1:0] sum_w,
    output logic [PW-1:0] cry_w
);

    logic [PW-1:0] maj;

    // Per-bit full adder: parity gives the sum bit, majority gives the saved carry.
    always_comb begin
        for (int k = 0; k < PW; k++) begin
            sum_w[k] = in_x[k] ^ in_y[k] ^ in_z[k];
            maj[k]   = (in_x[k] & in_y[k]) | (in_x[k] & in_z[k]) | (in_y[k] & in_z[k]);
        end
    end

    // Saved carries move up one weight position. The top majority bit is zero by the assumption above.
    assign cry_w = {maj[PW-2:0], 1'b0};

    logic unused_top;
    assign unused_top = maj[PW-1];

endmodule

// File: rtl/csam_cpa.sv
// Module: the single carry-propagate adder that merges the final sum and carry words.
// A plain ripple of full adders over PW bits. The carry out goes to the checks.
module csam_cpa #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] op_s,
    input  logic [PW-1:0] op_c,
    output logic [PW-1:0] total,
    output logic          cout
);

    logic [PW:0] rc;

    assign rc[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < PW; k++) begin : g_fa
            // One ripple position: sum bit and carry into the next position.
            assign total[k]  = op_s[k] ^ op_c[k] ^ rc[k];
            assign rc[k+1]   = (op_s[k] & op_c[k]) | (rc[k] & (op_s[k] ^ op_c[k]));
        end
    endgenerate

    assign cout = rc[PW];

endmodule

// File: rtl/csa_array_mult.sv
// Module: top of the unsigned carry-save array multiplier.
// Builds the partial-product rows and folds them through WIDTH-2 carry-save stages.
// One ripple adder at the end merges the two remaining words.
// OUT_REG selects a registered output (one clock of latency) or a purely combinational one.
// Assumes WIDTH >= 2. The reset is synchronous and active low, and acts on the output register only.
module csa_array_mult
    import csam_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int OUT_REG = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WIDTH-1:0]          op_a,
    input  logic [WIDTH-1:0]          op_b,
    output logic [2*WIDTH-1:0]        product
);

    localparam int PW    = prod_width(WIDTH);
    localparam int NSTG  = csa_stages(WIDTH);
    localparam int EW    = PW + 2;

    logic [WIDTH-1:0][PW-1:0] pp;
    logic [WIDTH-2:0][PW-1:0] acc_s;
    logic [WIDTH-2:0][PW-1:0] acc_c;
    logic [PW-1:0]            merged;
    logic                     merge_cout;

    initial begin
        AST_WIDTH_MIN: assert (WIDTH >= 2) else $error("WIDTH must be at least 2"); // R1
    end

    csam_pp_gen #(.N(WIDTH), .PW(PW)) u_pp (
        .mcand  (op_a),
        .mplier (op_b),
        .rows   (pp)
    );

    // The first two rows seed the running sum and carry words.
    assign acc_s[0] = pp[0];
    assign acc_c[0] = pp[1];

    genvar k;
    generate
        for (k = 1; k <= NSTG; k++) begin : g_stage
            csam_csa_row #(.PW(PW)) u_row (
                .in_x  (acc_s[k-1]),
                .in_y  (acc_c[k-1]),
                .in_z  (pp[k+1]),
                .sum_w (acc_s[k]),
                .cry_w (acc_c[k])
            );

            // Each stage keeps the total of its three inputs in its two outputs.
            AST_STAGE_CONSERVE: assert property (@(posedge clk) disable iff (!rst_n)
                EW'(acc_s[k-1]) + EW'(acc_c[k-1]) + EW'(pp[k+1])
                    == EW'(acc_s[k]) + EW'(acc_c[k])); // R3
        end
    endgenerate

    csam_cpa #(.PW(PW)) u_cpa (
        .op_s  (acc_s[WIDTH-2]),
        .op_c  (acc_c[WIDTH-2]),
        .total (merged),
        .cout  (merge_cout)
    );

    // The final two words together still hold the exact product.
    AST_CHAIN_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        EW'(acc_s[WIDTH-2]) + EW'(acc_c[WIDTH-2]) == EW'(op_a) * EW'(op_b)); // R4

    // The full-width final adder never overflows.
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        merge_cout == 1'b0); // R5

    // The merged result equals the arithmetic product.
    AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        merged == PW'(op_a) * PW'(op_b)); // R1

    generate
        if (OUT_REG != 0) begin : g_reg
            logic [PW-1:0] prod_q;

            // Output register: clear on reset, otherwise capture the merged product.
            always_ff @(posedge clk) begin
                if (!rst_n) prod_q <= '0;
                else        prod_q <= merged;
            end

            assign product = prod_q;

            // The output follows the previous cycle's operands.
            AST_REG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> product == PW'($past(op_a)) * PW'($past(op_b))); // R6

            // The first cycle after a reset edge shows a cleared output.
            AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> product == '0); // R7
        end else begin : g_comb
            assign product = merged;
        end
    endgenerate

endmodule

// File: tb/test_csa_array_mult.sv
// Bench: a behavioural queue model of the expected products, compared on every clock.
module test_csa_array_mult;

    localparam int  W          = 8;
    localparam int  PW         = 2 * W;
    localparam time CLK_PERIOD = 10;

    logic          clk   = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  a     = '0;
    logic [W-1:0]  b     = '0;
    logic [PW-1:0] p;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [PW-1:0] expq[$];
    string         reqq[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    csa_array_mult #(.WIDTH(W), .OUT_REG(1)) i_csa_array_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a    (a),
        .op_b    (b),
        .product (p)
    );

    task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // At a falling edge: check the result from the last capture, then drive new operands.
    task automatic step(input logic [W-1:0] na, input logic [W-1:0] nb, input string req);
        @(negedge clk);
        if (expq.size() > 0) check(reqq.pop_front(), p, expq.pop_front());
        a = na;
        b = nb;
        expq.push_back(PW'(na) * PW'(nb));
        reqq.push_back(req);
    endtask

    // Check whatever result is still pending in the queue.
    task automatic drain();
        @(negedge clk);
        if (expq.size() > 0) check(reqq.pop_front(), p, expq.pop_front());
    endtask

    initial begin
        // R7: while reset is held, the output stays zero under nonzero operands.
        a = 8'hA5;
        b = 8'h5A;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7 reset hold", p, '0);
        end
        rst_n = 1'b1;

        // R3: a small pattern whose rows need real carry-save folding.
        step(8'd3, 8'd7, "R3 small fold");
        step(8'd3, 8'd2, "R3 small fold");

        // R2: one-hot operands place a single bit at weight i+j.
        for (int i = 0; i < W; i++)
            for (int j = 0; j < W; j++)
                step(W'(1) << i, W'(1) << j, "R2 one-hot weight");

        // R4 / R5: dense and boundary operands.
        step(8'hFF, 8'hFF, "R5 max operands");
        step(8'hFF, 8'h01, "R4 max by one");
        step(8'h00, 8'hFF, "R4 zero operand");
        step(8'hAA, 8'h55, "R4 alternating bits");
        step(8'hFF, 8'hFE, "R4 dense carries");
        drain();

        // R6 / R7: a reset in mid-run overrides the pending result.
        @(negedge clk);
        rst_n = 1'b0;
        a = 8'hFF;
        b = 8'hFF;
        @(negedge clk);
        check("R7 mid-run reset clears", p, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 first result after reset", p, 16'hFE01);

        // R1 / R6: every operand pair, one per clock, checked one cycle later.
        for (int i = 0; i < (1 << W); i++)
            for (int j = 0; j < (1 << W); j++)
                step(W'(i), W'(j), "R1 exhaustive");
        drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule